// File: doc/BRIEF.md
# Pulse-Length Symbol Frame Transmitter

This block puts one frame onto a single-bit bus output that idles high. The length of a high run encodes each symbol, and a single low period closes every symbol. A frame is a start symbol, at least `MIN_DATA` data symbols of three kinds, and an end symbol. Every change on the output lines up with a period boundary. The boundary comes from a shared period tick. A local divider stands in for that tick when it is missing for `PERIOD_CLKS` clocks.

A start strobe arms the block. Data symbols come from upstream through a valid/ready handshake that opens once per symbol, during the low separator. A close request ends the frame, but only once enough data symbols have gone out. Until then the block pads with the shortest data symbol. Three status outputs report progress: frame active, end of frame, and detection stop. Detection stop rises partway through the end symbol, so that a collision checker elsewhere knows when to stop looking.

The controller has four states. `ST_IDLE` holds the output high. `ST_ARMED` waits for the next period boundary. `ST_HIGH` emits the high run of the current symbol, with a remaining-period count. `ST_LOW` emits the closing low period. The transitions are:
- *arm*: `ST_IDLE` to `ST_ARMED`, on a start strobe.
- *launch*: `ST_ARMED` to `ST_HIGH`, on a tick, loading the start symbol.
- *count*: `ST_HIGH` to `ST_HIGH`, on a tick while periods remain.
- *close_run*: `ST_HIGH` to `ST_LOW`, on a tick when the run is spent.
- *fetch*: `ST_LOW` to `ST_HIGH`, on a tick, loading a data, pad or end symbol.
- *finish*: `ST_LOW` to `ST_IDLE`, on a tick after the end symbol.
- *kill*: any state to `ST_IDLE`, on abort.

Top module: `pft_frame_tx`

## Requirements
- R1: During and after reset, with no start strobe, `bus_out` is 1 and `frame_active`, `eof_flag`, `det_stop` and `sym_ready` are 0.
- R2: After a start strobe, the first period tick begins the start symbol: 10 high periods, then one low period. `frame_active` stays 0 throughout the start symbol.
- R3: A data symbol accepted with `sym_code` 2'b01 gives 2 high periods, 2'b10 gives 4, and 2'b11 gives 6. Each is followed by one low period.
- R4: `sym_ready` is 1 only in the clock of the period tick that ends a low separator, and only when another symbol follows. It is never 1 after the end symbol's low period. A nonzero code with `sym_valid` high in that clock is the next symbol.
- R5: At a ready clock, `sym_valid` low or `sym_code` 2'b00 is a close request. Once `MIN_DATA` (15) data symbols have been sent, a close request starts the end symbol: 8 high periods, then one low period.
- R6: A close request before `MIN_DATA` data symbols have been sent is refused. A code 2'b01 pad symbol is sent in its place, and the pad counts towards the minimum.
- R7: `frame_active` is 1 from the tick that ends the start symbol's low period to the tick that ends the end symbol's low period.
- R8: `eof_flag` goes to 1 at the tick that ends the end symbol's low period. From then `bus_out` stays 1 and no more periods are emitted. `eof_flag` holds until the next start strobe or abort clears it.
- R9: `det_stop` is 1 during the end symbol once fewer than 7 of its high periods remain (from its third high period) and through its low period. It is 0 at every other time.
- R10: In the clock after `abort` is high, `bus_out` is 1, all three flags are 0 and the block is idle. A pending start strobe is dropped.
- R11: A start strobe while a frame is armed or in progress has no effect on the output.
- R12: Without a tick the output does not change. The period boundary comes from `period_tick`. If `period_tick` is missing for `PERIOD_CLKS` clocks, the local divider supplies the boundary instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | Shared period boundary pulse, one clock wide |
| abort | input | 1 | Halt at once and return to idle |
| start | input | 1 | Start strobe for one frame |
| sym_valid | input | 1 | Upstream symbol is valid |
| sym_code | input | 2 | Symbol code: 01/10/11 data, 00 close |
| sym_ready | output | 1 | Symbol accepted in this clock |
| bus_out | output | 1 | Bus bit, 1 = released/high |
| frame_active | output | 1 | Frame under way after the start symbol |
| eof_flag | output | 1 | Last frame completed |
| det_stop | output | 1 | Collision checking window closed |

## Verification
The bench attacks the minimum-length rule from both sides: a frame offered exactly 15 symbols, one offered 3, and one offered none. A design that counted wrongly would close early and send a short frame, or pad one symbol too many. The bench checks detection stop in every period of the end symbol, because an off-by-one in the remaining count moves its rise by a whole period. The bench also aborts during a low separator and while armed. A design that waited for the next tick, or kept the pending start, would leave the bus low or send a start symbol later. Finally, the bench withholds the shared tick to show that the divider takes over after exactly `PERIOD_CLKS` clocks.

// File: rtl/pft_pkg.sv
`timescale 1ns/1ps
package pft_pkg;

    localparam int CODE_W = 2;
    localparam int RUN_W  = 4;

    // high-run lengths in periods
    localparam logic [RUN_W-1:0] START_RUN  = 4'd10;
    localparam logic [RUN_W-1:0] END_RUN    = 4'd8;
    localparam logic [RUN_W-1:0] DET_WINDOW = 4'd7;

    localparam logic [CODE_W-1:0] CODE_CLOSE = 2'b00;
    localparam logic [CODE_W-1:0] CODE_PAD   = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HIGH,
        ST_LOW
    } pft_state_e;

    typedef enum logic [1:0] {
        K_START,
        K_DATA,
        K_END
    } pft_kind_e;

    // data kind n lasts 2*n high periods
    function automatic logic [RUN_W-1:0] data_run(input logic [CODE_W-1:0] code);
        return {{(RUN_W-CODE_W-1){1'b0}}, code, 1'b0};
    endfunction

endpackage

// File: rtl/pft_period_div.sv
`timescale 1ns/1ps
module pft_period_div #(
    parameter int PERIOD_CLKS = 78100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tick,
    output logic tick
);

    localparam int DW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
    localparam logic [DW-1:0] LAST = DW'(PERIOD_CLKS - 1);

    logic [DW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);
    assign tick = ext_tick | wrap;

    // shared tick realigns the local count; wrap covers a missing tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !tick || ext_tick); // R12

endmodule

// File: rtl/pft_data_cnt.sv
`timescale 1ns/1ps
module pft_data_cnt #(
    parameter int MIN_DATA = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic min_met
);

    localparam int CW = $clog2(MIN_DATA + 1);
    localparam logic [CW-1:0] TARGET = CW'(MIN_DATA);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (incr && (cnt_q != TARGET)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign min_met = (cnt_q == TARGET);

    AST_CNT_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear, incr})); // R6

endmodule

// File: rtl/pft_frame_tx.sv
`timescale 1ns/1ps
module pft_frame_tx
    import pft_pkg::*;
#(
    parameter int PERIOD_CLKS = 78100,
    parameter int MIN_DATA    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_tick,
    input  logic              abort,
    input  logic              start,
    input  logic              sym_valid,
    input  logic [CODE_W-1:0] sym_code,
    output logic              sym_ready,
    output logic              bus_out,
    output logic              frame_active,
    output logic              eof_flag,
    output logic              det_stop
);

    pft_state_e       st_q, st_d;
    pft_kind_e        kind_q, kind_d;
    logic [RUN_W-1:0] rem_q, rem_d;
    logic             eof_q, eof_d;
    logic             tick;
    logic             cnt_clr, cnt_inc, min_met;
    logic             take_data;

    pft_period_div #(.PERIOD_CLKS(PERIOD_CLKS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_tick (period_tick),
        .tick     (tick)
    );

    pft_data_cnt #(.MIN_DATA(MIN_DATA)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clr),
        .incr    (cnt_inc),
        .min_met (min_met)
    );

    assign take_data = sym_valid && (sym_code != CODE_CLOSE);

    // next-state logic
    always_comb begin
        st_d    = st_q;
        kind_d  = kind_q;
        rem_d   = rem_q;
        eof_d   = eof_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (abort) begin
            st_d   = ST_IDLE;
            kind_d = K_START;
            rem_d  = '0;
            eof_d  = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_d  = ST_ARMED;
                        eof_d = 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (tick) begin
                        st_d    = ST_HIGH;
                        kind_d  = K_START;
                        rem_d   = START_RUN - 1'b1;
                        cnt_clr = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (rem_q == '0) begin
                            st_d = ST_LOW;
                        end else begin
                            rem_d = rem_q - 1'b1;
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        if (kind_q == K_END) begin
                            st_d   = ST_IDLE;
                            kind_d = K_START;
                            eof_d  = 1'b1;
                        end else begin
                            st_d = ST_HIGH;
                            if (take_data) begin
                                kind_d  = K_DATA;
                                rem_d   = data_run(sym_code) - 1'b1;
                                cnt_inc = 1'b1;
                            end else if (min_met) begin
                                kind_d = K_END;
                                rem_d  = END_RUN - 1'b1;
                            end else begin
                                kind_d  = K_DATA;
                                rem_d   = data_run(CODE_PAD) - 1'b1;
                                cnt_inc = 1'b1;
                            end
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= K_START;
            rem_q  <= '0;
            eof_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            rem_q  <= rem_d;
            eof_q  <= eof_d;
        end
    end

    // outputs
    always_comb begin
        bus_out      = (st_q != ST_LOW);
        frame_active = ((st_q == ST_HIGH) || (st_q == ST_LOW)) && (kind_q != K_START);
        det_stop     = (kind_q == K_END) &&
                       (((st_q == ST_HIGH) && (rem_q < DET_WINDOW - 1'b1)) || (st_q == ST_LOW));
        sym_ready    = (st_q == ST_LOW) && (kind_q != K_END) && tick && !abort;
        eof_flag     = eof_q;
    end

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> bus_out && !frame_active && !det_stop && !eof_flag); // R10

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !abort) |=> $stable(bus_out)); // R12

    AST_READY_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready |=> bus_out && !sym_ready); // R4

    AST_DET_BEFORE_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eof_flag) |-> $past(det_stop)); // R9

    AST_END_NEEDS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && kind_q == K_END && $past(st_q) == ST_LOW) |-> min_met); // R6

    AST_ACTIVE_NO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active |-> !eof_flag); // R8

endmodule

// File: tb/pft_frame_tx_test.sv
`timescale 1ns/1ps
module pft_frame_tx_test;

    localparam int PER_CLKS = 32;
    localparam int GAP      = 7;
    localparam int MIN_D    = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_tick = 1'b0;
    logic       abort = 1'b0;
    logic       start = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_code = 2'b00;
    logic       sym_ready, bus_out, frame_active, eof_flag, det_stop;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pft_frame_tx #(.PERIOD_CLKS(PER_CLKS), .MIN_DATA(MIN_D)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_tick  (period_tick),
        .abort        (abort),
        .start        (start),
        .sym_valid    (sym_valid),
        .sym_code     (sym_code),
        .sym_ready    (sym_ready),
        .bus_out      (bus_out),
        .frame_active (frame_active),
        .eof_flag     (eof_flag),
        .det_stop     (det_stop)
    );

    // columns: offered data symbols, code seed, close as valid 00, start poke, expected data sent
    localparam int CASES [5][5] = '{
        '{15, 1, 1, 0, 15},
        '{20, 2, 0, 1, 20},
        '{ 3, 1, 1, 0, 15},
        '{ 0, 1, 0, 0, 15},
        '{16, 5, 1, 0, 16}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick(input bit v, input logic [1:0] c, output bit r);
        repeat (GAP) @(negedge clk);
        period_tick = 1'b1;
        sym_valid   = v;
        sym_code    = c;
        #1;
        r = sym_ready;
        @(negedge clk);
        period_tick = 1'b0;
        sym_valid   = 1'b0;
        sym_code    = 2'b00;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    function automatic logic [1:0] code_of(input int j, input int seed);
        return 2'(((j * seed + j / 3) % 3) + 1);
    endfunction

    // checks one symbol: len high periods then the low period; returns in the low period
    task automatic emit_run(input int len, input bit is_end, input bit act,
                            input string req, input bit poke);
        bit r;
        for (int i = 0; i < len; i++) begin
            chk(req, bus_out, 1);
            chk("R7", frame_active, act);
            chk("R9", det_stop, (is_end && (len - i) < 7) ? 1 : 0);
            if (poke && i == 0) pulse_start();
            do_tick(1'b0, 2'b00, r);
            chk("R4", r, 0);
        end
        chk(req, bus_out, 0);
        chk("R7", frame_active, act);
        chk("R9", det_stop, is_end ? 1 : 0);
    endtask

    task automatic run_case(input int nd, input int seed, input bit code0,
                            input bit poke, input int sent);
        bit r;
        logic [1:0] c;
        pulse_start();
        chk("R2", bus_out, 1);
        do_tick(1'b0, 2'b00, r);
        chk("R4", r, 0);
        emit_run(10, 1'b0, 1'b0, "R2", 1'b0);
        for (int j = 0; j < sent; j++) begin
            if (j < nd) begin
                c = code_of(j, seed);
                do_tick(1'b1, c, r);
                chk("R4", r, 1);
                emit_run(2 * int'(c), 1'b0, 1'b1, poke && j == 0 ? "R11" : "R3", poke && j == 0);
            end else begin
                do_tick(code0, 2'b00, r);
                chk("R4", r, 1);
                emit_run(2, 1'b0, 1'b1, "R6", 1'b0);
            end
        end
        do_tick(code0, 2'b00, r);
        chk("R5", r, 1);
        emit_run(8, 1'b1, 1'b1, "R5", 1'b0);
        do_tick(1'b0, 2'b00, r);
        chk("R4", r, 0);
        chk("R8", bus_out, 1);
        chk("R8", eof_flag, 1);
        chk("R7", frame_active, 0);
        chk("R9", det_stop, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got no completion expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit r;
        repeat (3) @(negedge clk);
        chk("R1", bus_out, 1);
        chk("R1", frame_active, 0);
        chk("R1", eof_flag, 0);
        chk("R1", det_stop, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", bus_out, 1);
        chk("R1", sym_ready, 0);
        chk("R1", eof_flag, 0);

        // R12: armed but no tick, nothing moves
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R12", bus_out, 1);
        chk("R12", frame_active, 0);
        pulse_abort();

        for (int k = 0; k < 5; k++) begin
            run_case(CASES[k][0], CASES[k][1], CASES[k][2] != 0, CASES[k][3] != 0, CASES[k][4]);
        end

        // R8: eof holds, bus stays high with no further output
        for (int i = 0; i < 3; i++) begin
            do_tick(1'b1, 2'b11, r);
            chk("R8", r, 0);
            chk("R8", eof_flag, 1);
            chk("R8", bus_out, 1);
        end
        pulse_start();
        chk("R8", eof_flag, 0);

        // R10: abort while armed drops the pending start
        pulse_abort();
        for (int i = 0; i < 12; i++) begin
            do_tick(1'b0, 2'b00, r);
            chk("R10", bus_out, 1);
        end

        // R10: abort during a low separator releases the bus at once
        pulse_start();
        for (int i = 0; i < 11; i++) do_tick(1'b0, 2'b00, r);
        chk("R2", bus_out, 0);
        pulse_abort();
        chk("R10", bus_out, 1);
        chk("R10", frame_active, 0);

        // R10: abort inside a data symbol
        pulse_start();
        for (int i = 0; i < 11; i++) do_tick(1'b0, 2'b00, r);
        do_tick(1'b1, 2'b11, r);
        chk("R7", frame_active, 1);
        pulse_abort();
        chk("R10", frame_active, 0);
        chk("R10", bus_out, 1);
        chk("R10", eof_flag, 0);

        // R12: missing shared tick, the divider ends the period after PER_CLKS clocks
        pulse_start();
        for (int i = 0; i < 11; i++) do_tick(1'b0, 2'b00, r);
        chk("R2", bus_out, 0);
        repeat (30) @(negedge clk);
        chk("R12", bus_out, 0);
        repeat (2) @(negedge clk);
        chk("R12", bus_out, 1);
        pulse_abort();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule